// File: doc/BRIEF.md
# Interrupt-Driven DMA Channel Controller

This block is one DMA channel attached to a single peripheral interrupt source. Software loads a transaction count and a byte pointer, picks the target space (main memory or register file) and one of two page registers, and unmasks the channel. Each time the peripheral flags an event, the channel raises a request. The request is served only when its priority is not below the current CPU priority, no top-level interrupt service is running, and the CPU is at an instruction boundary. In that cycle one byte moves between the peripheral and the addressed location. The direction follows the peripheral type.

After every transfer the pointer steps up by one and the count steps down by one. When the count runs out, the channel masks itself and holds an end-of-block flag. The flag drives the interrupt output while its enable bit is set. A channel that is unmasked with a count of zero performs no transfer and goes straight to end-of-block.

Top module: `irq_dma_channel`

## Requirements
- R1: `dma_req` is high exactly when the pending flag is set, the DMA mask is set and the count is non-zero.
- R2: A transfer (`mem_req` high) happens only in a cycle where `dma_req`, `instr_end` and `src_prio >= cpu_prio` (unsigned) all hold and `top_busy` is low. Equal priorities are served.
- R3: A transfer addresses `{page, ptr}`. On the following edge `ptr` increments by one, wrapping at the register width, and the count decrements by one.
- R4: With `dir_rx`=1 a transfer writes memory (`mem_we`=1, `mem_wdata`=`periph_rdata`, `periph_we`=0). With `dir_rx`=0 it reads memory and writes the peripheral (`mem_we`=0, `periph_we`=1, `periph_wdata`=`mem_rdata`).
- R5: A transfer clears the pending flag, so one event gives one transfer. A pulse on `evt_pend` sets the flag, and this wins over a clear in the same cycle. Control bit 4 written as 1 also sets the flag.
- R6: A transfer made with a count of 1 clears the DMA mask and sets the end-of-block flag. `eob_irq` is the end-of-block flag ANDed with the enable bit (control bit 3). Writing control bit 5 as 1 clears the flag.
- R7: If the mask is set while the count is 0, no transfer occurs. On the next edge the mask clears and the end-of-block flag sets.
- R8: Control bit 1 chooses the page: 0 selects `page_a` and 1 selects `page_b`. The page forms the upper half of `mem_addr`.
- R9: Control bit 0 chooses the target space: 0 is memory and 1 is the register file. `mem_rf` shows this bit.
- R10: While the register-file target is selected, a pointer write above DFh is rejected and the pointer keeps its old value.
- R11: After reset every state bit, the count and the pointer are zero, and `dma_req`, `mem_req` and `eob_irq` are low.
- R12: A register write to a field takes effect over any hardware update of that field in the same cycle. Select codes: 0 is control (bit 2 = DMA mask), 1 is count, 2 is pointer, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 count, 2 pointer) |
| reg_wdata | input | 8 | Register write data |
| evt_pend | input | 1 | Peripheral event, sets the pending flag |
| src_prio | input | 3 | Priority level of this source |
| cpu_prio | input | 3 | Current CPU priority level |
| top_busy | input | 1 | Top-level interrupt service in progress |
| instr_end | input | 1 | Instruction-boundary strobe |
| dir_rx | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| page_a | input | 8 | First page register value |
| page_b | input | 8 | Second page register value |
| periph_rdata | input | 8 | Data from the peripheral |
| mem_rdata | input | 8 | Read data from memory |
| dma_req | output | 1 | Request raised |
| mem_req | output | 1 | Transfer in this cycle |
| mem_we | output | 1 | Memory write enable |
| mem_rf | output | 1 | Target is the register file |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 8 | Memory write data |
| periph_we | output | 1 | Peripheral write enable |
| periph_wdata | output | 8 | Data to the peripheral |
| eob_irq | output | 1 | End-of-block interrupt |

## Verification
Request, transfer strobe, address, direction and data outputs are combinational in the cycle where the grant conditions hold. Pointer, count, mask, pending and end-of-block updates show one rising edge later.

The bench drives inputs at the falling edge and samples 1 ns later. It advances its own reference state only after that sample, so each comparison uses the state as it stood before the next rising edge.

Seeded random traffic is mixed with directed cases: equal priority, busy top level, a count of zero, the last transfer, a rejected pointer, and a write colliding with a grant.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
    parameter int REG_W  = 8;
    parameter int PAGE_W = 8;
    parameter int PRIO_W = 3;
    parameter int DATA_W = 8;
    parameter int ADDR_W = PAGE_W + REG_W;

    localparam int CTL_RF     = 0;
    localparam int CTL_PSEL   = 1;
    localparam int CTL_MASK   = 2;
    localparam int CTL_IE     = 3;
    localparam int CTL_SWPEND = 4;
    localparam int CTL_EOBCLR = 5;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_PTR   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             rf;
        logic             psel;
        logic             mask;
        logic             ie;
        logic             pend;
        logic             eob;
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] ptr;
    } chan_st_t;
endpackage

// File: rtl/dmach_gate.sv
module dmach_gate
    import dmach_pkg::*;
(
    input  logic              pend,
    input  logic              mask,
    input  logic              cnt_zero,
    input  logic [PRIO_W-1:0] src_prio,
    input  logic [PRIO_W-1:0] cpu_prio,
    input  logic              top_busy,
    input  logic              instr_end,
    output logic              req,
    output logic              grant
);
    logic prio_ok;

    always_comb begin
        req     = pend && mask && !cnt_zero;
        prio_ok = (src_prio >= cpu_prio);
        grant   = req && prio_ok && instr_end && !top_busy;
    end
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr
    import dmach_pkg::*;
(
    input  logic              psel,
    input  logic [PAGE_W-1:0] page_a,
    input  logic [PAGE_W-1:0] page_b,
    input  logic [REG_W-1:0]  ptr,
    output logic [ADDR_W-1:0] addr
);
    logic [PAGE_W-1:0] page;

    always_comb begin
        page = psel ? page_b : page_a;
        addr = {page, ptr};
    end
endmodule

// File: rtl/irq_dma_channel.sv
module irq_dma_channel
    import dmach_pkg::*;
#(
    parameter logic [REG_W-1:0] RF_LIMIT = REG_W'('hDF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              evt_pend,
    input  logic [PRIO_W-1:0] src_prio,
    input  logic [PRIO_W-1:0] cpu_prio,
    input  logic              top_busy,
    input  logic              instr_end,
    input  logic              dir_rx,
    input  logic [PAGE_W-1:0] page_a,
    input  logic [PAGE_W-1:0] page_b,
    input  logic [DATA_W-1:0] periph_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dma_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_rf,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              periph_we,
    output logic [DATA_W-1:0] periph_wdata,
    output logic              eob_irq
);
    chan_st_t st_d, st_q;
    logic     cnt_zero;
    logic     grant;

    logic             chk_mask;
    logic             chk_eob;
    logic [REG_W-1:0] chk_ptr;

    assign cnt_zero = (st_q.cnt == '0);

    dmach_gate u_gate (
        .pend      (st_q.pend),
        .mask      (st_q.mask),
        .cnt_zero  (cnt_zero),
        .src_prio  (src_prio),
        .cpu_prio  (cpu_prio),
        .top_busy  (top_busy),
        .instr_end (instr_end),
        .req       (dma_req),
        .grant     (grant)
    );

    dmach_addr u_addr (
        .psel   (st_q.psel),
        .page_a (page_a),
        .page_b (page_b),
        .ptr    (st_q.ptr),
        .addr   (mem_addr)
    );

    always_comb begin
        st_d = st_q;
        // unmasked with nothing left: straight to end-of-block
        if (st_q.mask && cnt_zero) begin
            st_d.mask = 1'b0;
            st_d.eob  = 1'b1;
        end
        if (grant) begin
            st_d.ptr  = st_q.ptr + 1'b1;
            st_d.cnt  = st_q.cnt - 1'b1;
            st_d.pend = 1'b0;
            if (st_q.cnt == REG_W'(1)) begin
                st_d.mask = 1'b0;
                st_d.eob  = 1'b1;
            end
        end
        if (evt_pend) begin
            st_d.pend = 1'b1;
        end
        if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTRL: begin
                    st_d.rf   = reg_wdata[CTL_RF];
                    st_d.psel = reg_wdata[CTL_PSEL];
                    st_d.mask = reg_wdata[CTL_MASK];
                    st_d.ie   = reg_wdata[CTL_IE];
                    if (reg_wdata[CTL_SWPEND]) st_d.pend = 1'b1;
                    if (reg_wdata[CTL_EOBCLR]) st_d.eob  = 1'b0;
                end
                SEL_COUNT: st_d.cnt = reg_wdata;
                SEL_PTR: begin
                    if (!(st_q.rf && (reg_wdata > RF_LIMIT))) begin
                        st_d.ptr = reg_wdata;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        mem_req      = grant;
        mem_we       = grant && dir_rx;
        periph_we    = grant && !dir_rx;
        mem_rf       = st_q.rf;
        mem_wdata    = periph_rdata;
        periph_wdata = mem_rdata;
        eob_irq      = st_q.eob && st_q.ie;
        chk_mask     = st_q.mask;
        chk_eob      = st_q.eob;
        chk_ptr      = st_q.ptr;
    end
endmodule

// File: rtl/dmach_checker.sv
module dmach_checker
    import dmach_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              evt_pend,
    input logic [PRIO_W-1:0] src_prio,
    input logic [PRIO_W-1:0] cpu_prio,
    input logic              top_busy,
    input logic              instr_end,
    input logic              dir_rx,
    input logic              dma_req,
    input logic              mem_req,
    input logic              mem_we,
    input logic              periph_we,
    input logic              mask_flag,
    input logic              eob_flag,
    input logic [REG_W-1:0]  ptr_val
);
    p_req_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> mask_flag);

    p_grant_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (dma_req && instr_end && !top_busy && (src_prio >= cpu_prio)));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !reg_we) |=> (ptr_val == $past(ptr_val) + 1'b1));

    p_direction_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_we == dir_rx) && (periph_we == !dir_rx)));

    p_one_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !evt_pend && !reg_we) |=> !mem_req);

    p_term_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eob_flag) && !$past(reg_we)) |-> !mask_flag);
endmodule

bind irq_dma_channel dmach_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .evt_pend  (evt_pend),
    .src_prio  (src_prio),
    .cpu_prio  (cpu_prio),
    .top_busy  (top_busy),
    .instr_end (instr_end),
    .dir_rx    (dir_rx),
    .dma_req   (dma_req),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .periph_we (periph_we),
    .mask_flag (chk_mask),
    .eob_flag  (chk_eob),
    .ptr_val   (chk_ptr)
);

// File: tb/irq_dma_channel_test.sv
`timescale 1ns/1ps
module irq_dma_channel_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic [1:0] reg_sel;
    logic [7:0] reg_wdata;
    logic       evt_pend;
    logic [2:0] src_prio, cpu_prio;
    logic       top_busy, instr_end, dir_rx;
    logic [7:0] page_a, page_b, periph_rdata, mem_rdata;
    logic       dma_req, mem_req, mem_we, mem_rf, periph_we, eob_irq;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata, periph_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    bit m_rf, m_psel, m_mask, m_ie, m_pend, m_eob;
    logic [7:0] m_cnt, m_ptr;

    always #5 clk = ~clk;

    irq_dma_channel uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .evt_pend(evt_pend), .src_prio(src_prio),
        .cpu_prio(cpu_prio), .top_busy(top_busy), .instr_end(instr_end),
        .dir_rx(dir_rx), .page_a(page_a), .page_b(page_b),
        .periph_rdata(periph_rdata), .mem_rdata(mem_rdata),
        .dma_req(dma_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_rf(mem_rf), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .periph_we(periph_we), .periph_wdata(periph_wdata), .eob_irq(eob_irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_req();
        return m_pend && m_mask && (m_cnt != 8'd0);
    endfunction

    function automatic bit exp_grant();
        return exp_req() && instr_end && !top_busy && (src_prio >= cpu_prio);
    endfunction

    task automatic idle_inputs();
        reg_we = 0; reg_sel = 0; reg_wdata = 0; evt_pend = 0;
        instr_end = 0; top_busy = 0;
    endtask

    // inputs are set at a falling edge; sample, then advance the reference
    task automatic tick();
        bit g;
        #1;
        g = exp_grant();
        check("R1 dma_req", {15'd0, dma_req}, {15'd0, exp_req()});
        check("R2 mem_req", {15'd0, mem_req}, {15'd0, g});
        check("R9 mem_rf", {15'd0, mem_rf}, {15'd0, m_rf});
        check("R6 eob_irq", {15'd0, eob_irq}, {15'd0, m_eob && m_ie});
        if (g) begin
            check("R3 addr low", {8'd0, mem_addr[7:0]}, {8'd0, m_ptr});
            check("R8 addr page", {8'd0, mem_addr[15:8]}, {8'd0, m_psel ? page_b : page_a});
            check("R4 mem_we", {15'd0, mem_we}, {15'd0, dir_rx});
            check("R4 periph_we", {15'd0, periph_we}, {15'd0, !dir_rx});
            if (dir_rx) check("R4 wdata", {8'd0, mem_wdata}, {8'd0, periph_rdata});
            else        check("R4 pdata", {8'd0, periph_wdata}, {8'd0, mem_rdata});
        end
        if (m_mask && m_cnt == 8'd0) begin m_mask = 0; m_eob = 1; end
        if (g) begin
            m_ptr = m_ptr + 8'd1;
            m_cnt = m_cnt - 8'd1;
            m_pend = 0;
            if (m_cnt == 8'd0) begin m_mask = 0; m_eob = 1; end
        end
        if (evt_pend) m_pend = 1;
        if (reg_we) begin
            case (reg_sel)
                2'd0: begin
                    m_rf = reg_wdata[0]; m_psel = reg_wdata[1];
                    m_mask = reg_wdata[2]; m_ie = reg_wdata[3];
                    if (reg_wdata[4]) m_pend = 1;
                    if (reg_wdata[5]) m_eob = 0;
                end
                2'd1: m_cnt = reg_wdata;
                2'd2: if (!(m_rf && reg_wdata > 8'hDF)) m_ptr = reg_wdata;
                default: ;
            endcase
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        rst_n = 0; idle_inputs();
        src_prio = 3; cpu_prio = 3; dir_rx = 1;
        page_a = 8'h12; page_b = 8'h34; periph_rdata = 8'hA5; mem_rdata = 8'h5A;
        {m_rf, m_psel, m_mask, m_ie, m_pend, m_eob} = '0; m_cnt = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R11 reset dma_req", {15'd0, dma_req}, 16'd0);
        check("R11 reset mem_req", {15'd0, mem_req}, 16'd0);
        check("R11 reset eob_irq", {15'd0, eob_irq}, 16'd0);
        @(negedge clk);
        rst_n = 1;

        // memory target, page_b, count 2, pointer 10h
        wr(2'd1, 8'd2);
        wr(2'd2, 8'h10);
        wr(2'd0, 8'b0000_1110);
        evt_pend = 1; tick();
        // R2: no boundary, then lower source priority, then busy
        tick();
        instr_end = 1; cpu_prio = 4; tick();
        instr_end = 1; cpu_prio = 3; top_busy = 1; tick();
        // R2: equal priority is served
        instr_end = 1; #1;
        check("R2 equal prio grant", {15'd0, mem_req}, 16'd1);
        check("R8 page_b", {8'd0, mem_addr[15:8]}, 16'h0034);
        tick();
        // R5: pending gone, no second transfer
        instr_end = 1; #1;
        check("R5 no repeat", {15'd0, mem_req}, 16'd0);
        tick();
        // last transfer, R6 end-of-block
        evt_pend = 1; tick();
        instr_end = 1; dir_rx = 0; tick();
        check("R6 eob raised", {15'd0, eob_irq}, 16'd1);
        check("R6 mask cleared", {15'd0, dma_req}, 16'd0);
        wr(2'd0, 8'b0010_1000);
        check("R6 eob cleared", {15'd0, eob_irq}, 16'd0);

        // R7: unmask with count 0
        wr(2'd0, 8'b0000_1100);
        evt_pend = 1; instr_end = 1; #1;
        check("R7 no transfer", {15'd0, mem_req}, 16'd0);
        tick();
        check("R7 eob", {15'd0, eob_irq}, 16'd1);
        wr(2'd0, 8'b0010_0000);

        // R10: register-file target rejects pointer above DFh
        wr(2'd0, 8'b0000_0001);
        wr(2'd2, 8'h20);
        wr(2'd2, 8'hE5);
        wr(2'd1, 8'd4);
        wr(2'd0, 8'b0000_0101);
        instr_end = 1; #1;
        check("R10 ptr kept", {8'd0, mem_addr[7:0]}, 16'h0020);
        check("R8 page_a", {8'd0, mem_addr[15:8]}, 16'h0012);
        check("R9 rf target", {15'd0, mem_rf}, 16'd1);
        tick();
        // R12: pointer write in the grant cycle wins
        evt_pend = 1; tick();
        instr_end = 1; reg_we = 1; reg_sel = 2'd2; reg_wdata = 8'h40; tick();
        evt_pend = 1; tick();
        instr_end = 1; #1;
        check("R12 write wins", {8'd0, mem_addr[7:0]}, 16'h0040);
        tick();

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                reg_we = 1; reg_sel = 2'($urandom_range(0, 3));
                reg_wdata = 8'($urandom);
                if (reg_sel == 2'd1) reg_wdata = 8'($urandom_range(0, 6));
                if (reg_sel == 2'd0) reg_wdata[2] = ($urandom_range(0, 3) != 0);
            end
            evt_pend     = ($urandom_range(0, 2) == 0);
            instr_end    = $urandom_range(0, 1);
            top_busy     = ($urandom_range(0, 7) == 0);
            src_prio     = 3'($urandom);
            cpu_prio     = 3'($urandom);
            dir_rx       = $urandom_range(0, 1);
            page_a       = 8'($urandom);
            page_b       = 8'($urandom);
            periph_rdata = 8'($urandom);
            mem_rdata    = 8'($urandom);
            tick();
        end
        done = 1'b1;
        summary();
    end
endmodule